// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a bus slave that behaves like a small serial EEPROM on a two-wire bus. It samples the clock and data lines with the system clock and finds START, repeated START and STOP on them. It decodes the device-select byte, keeps an internal address pointer, stores written bytes at that pointer and streams stored bytes back on reads. The block only ever pulls the data line low. Its output is a pull-low enable for an external open-drain driver.

Three strap inputs set the device's sub-address. In the narrow mode, a memory larger than 256 bytes takes the strap positions it needs from the select byte as upper memory address bits, and compares only the remaining positions against the straps. In the wide mode, two address bytes are sent after the select byte, high byte first, and all three strap bits are compared.

After a STOP that ends a write in which at least one byte was stored, the block spends a programmable number of system clocks in an internal write cycle. During that time it stays silent on the bus. A write-protect input refuses data bytes.

Top module: `eep_slave`

## Requirements
- R1: The block acknowledges a select byte only when its bits 7:4 are 1010 and every strap-compared position matches its strap pin: select bit j+1 is compared with strap bit j. A select byte that fails this check is not acknowledged, and the block stays silent until the next START.
- R2: In narrow mode with MEM_BYTES = 512, select bit 1 is not compared and becomes memory address bit 8 when the following address byte loads the pointer. Select bits 3:2 are compared with strap bits 2:1.
- R3: After a select with bit 0 = 0 (write), the first byte is acknowledged and loads the pointer. Every further byte is acknowledged, stored at the pointer, and then the pointer increases by one.
- R4: After a select with bit 0 = 1 (read), the block sends the byte at the pointer, MSB first. The pointer increases by one after each byte sent, and each master ACK (data low on the ninth pulse) makes the block send the next byte.
- R5: The pointer wraps from MEM_BYTES-1 to 0. This holds for reads and for writes.
- R6: A master NACK (data high on the ninth pulse) after a read byte ends the read. The pull-low enable stays inactive until the next START.
- R7: A STOP that ends a write with at least one stored byte starts a busy period of BUSY_CLKS system clocks. During that period no select byte is acknowledged and the data line is never pulled. Once the period has ended, selection works again.
- R8: While the write-protect input is high, the address byte of a write is still acknowledged. Data bytes are not acknowledged and not stored, and no busy period follows.
- R9: With WIDE_ADDR = 1, a write select is followed by two address bytes, high byte first, and all three strap bits are compared.
- R10: The pull-low enable changes only while the synchronized clock line is low. It is inactive while the block is idle or ignoring the bus.
- R11: After reset, the pull-low enable is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Sub-address strap pins |
| wp_i | input | 1 | Write-protect input, high refuses data bytes |
| sda_pull_o | output | 1 | Pull data line low when high |

## Verification
The assertions assume that the bus clock line holds each level for several system clocks. They also assume that the master changes data only while the clock is low, except when it makes START and STOP, and that it never issues START or STOP while this slave is pulling the line. The bench master builds every bus phase from quarter periods of eight system clocks. It drives data only in the low phase and releases the line during acknowledge and read phases, so the stimulus stays inside those assumptions.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_TXNEXT, S_IGNORE
  } st_t;

  typedef enum logic [1:0] {
    K_SEL, K_AHI, K_ALO, K_DATA
  } kind_t;

  // number of select-byte strap positions borrowed as address bits
  function automatic int borrow_bits(input int aw, input bit wide);
    int n;
    n = (wide || aw <= 8) ? 0 : aw - 8;
    if (n > 3) n = 3;
    return n;
  endfunction

  // device select match: family code plus the strap positions not borrowed
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap,
                                     input int borrowed);
    logic ok;
    ok = (b[7:4] == 4'b1010);
    for (int j = 0; j < 3; j++)
      if (j >= borrowed && b[j+1] != strap[j]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/eep_sync.sv
`timescale 1ns/1ps
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_mem.sv
`timescale 1ns/1ps
module eep_mem #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eep_slave.sv
`timescale 1ns/1ps
module eep_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter bit WIDE_ADDR = 1'b0,
  parameter int BUSY_CLKS = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int BRW = borrow_bits(AW, WIDE_ADDR);
  localparam int BW  = $clog2(BUSY_CLKS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_t           st;
  kind_t         kind;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [7:0]    addr_hi;
  logic [2:0]    sel_hi;
  logic          rd;
  logic          wr_pend;
  logic [AW-1:0] ptr;
  logic [BW-1:0] busy_cnt;
  logic          pull;

  // named events for assertions
  logic          rx_done, sel_ok, mem_we, busy;
  logic [7:0]    rdata;
  logic [AW-1:0] load_ptr;

  assign rx_done = (st == S_RX) && scl_fall && (cnt == 4'd8);
  assign busy    = (busy_cnt != '0);
  assign sel_ok  = dev_match(sh, strap_i, BRW) && !busy;
  assign mem_we  = rx_done && (kind == K_DATA) && !wp_i;

  always_comb begin
    logic [15:0] wide_a;
    logic [10:0] narrow_a;
    wide_a   = {addr_hi, sh};
    narrow_a = {sel_hi, sh};
    load_ptr = WIDE_ADDR ? wide_a[AW-1:0] : narrow_a[AW-1:0];
  end

  eep_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(sh), .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_SEL;
      cnt      <= '0;
      sh       <= '0;
      addr_hi  <= '0;
      sel_hi   <= '0;
      rd       <= 1'b0;
      wr_pend  <= 1'b0;
      ptr      <= '0;
      busy_cnt <= '0;
      pull     <= 1'b0;
    end else if (stop_det) begin
      st      <= S_IDLE;
      pull    <= 1'b0;
      wr_pend <= 1'b0;
      if (wr_pend) busy_cnt <= BW'(BUSY_CLKS);
      else if (busy) busy_cnt <= busy_cnt - BW'(1);
    end else begin
      if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (start_det) begin
        st   <= S_RX;
        kind <= K_SEL;
        cnt  <= '0;
        pull <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (rx_done) begin
              cnt <= '0;
              case (kind)
                K_SEL: begin
                  if (sel_ok) begin
                    pull   <= 1'b1;
                    st     <= S_RXACK;
                    rd     <= sh[0];
                    sel_hi <= sh[3:1];
                    kind   <= WIDE_ADDR ? K_AHI : K_ALO;
                  end else begin
                    st <= S_IGNORE;
                  end
                end
                K_AHI: begin
                  addr_hi <= sh;
                  pull    <= 1'b1;
                  st      <= S_RXACK;
                  kind    <= K_ALO;
                end
                K_ALO: begin
                  ptr  <= load_ptr;
                  pull <= 1'b1;
                  st   <= S_RXACK;
                  kind <= K_DATA;
                end
                default: begin
                  if (wp_i) begin
                    st <= S_IGNORE;
                  end else begin
                    ptr     <= ptr + AW'(1);
                    wr_pend <= 1'b1;
                    pull    <= 1'b1;
                    st      <= S_RXACK;
                  end
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd) begin
                st   <= S_TX;
                sh   <= rdata;
                pull <= ~rdata[7];
              end else begin
                st   <= S_RX;
                pull <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                pull <= 1'b0;
                st   <= S_TXACK;
              end else begin
                pull <= ~sh[6];
                sh   <= {sh[6:0], 1'b0};
                cnt  <= cnt + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              ptr <= ptr + AW'(1);
              st  <= sda_s ? S_IGNORE : S_TXNEXT;
            end
          end
          S_TXNEXT: begin
            if (scl_fall) begin
              st   <= S_TX;
              sh   <= rdata;
              pull <= ~rdata[7];
              cnt  <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;

  // the line is left alone while idle or ignoring the bus
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_IGNORE) |-> !sda_pull_o);

  // the drive changes only in the low phase of the bus clock
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

  // no drive at all during the internal write cycle
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // every stored byte advances the pointer by one, wrapping
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + AW'(1)));

  // a refused read ends in the ignore state after the master NACK
  p_nack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TXACK && scl_rise && sda_s && !stop_det && !start_det) |=> (st == S_IGNORE));

endmodule

// File: tb/sim_eep_slave.sv
`timescale 1ns/1ps
module sim_eep_slave;
  localparam int CLK_NS = 10;
  localparam int Q = 8 * CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic wp0 = 1'b0;
  logic p0, p1;
  logic sda_line;
  int   errors = 0;
  int   checks = 0;

  assign sda_line = ~(m_pull | p0 | p1);

  always #(CLK_NS/2) clk = ~clk;

  eep_slave #(.MEM_BYTES(512), .WIDE_ADDR(1'b0), .BUSY_CLKS(500)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(3'b000), .wp_i(wp0), .sda_pull_o(p0)
  );

  eep_slave #(.MEM_BYTES(256), .WIDE_ADDR(1'b1), .BUSY_CLKS(500)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(3'b101), .wp_i(1'b0), .sda_pull_o(p1)
  );

  logic [7:0] mdl0 [512];

  // {address, data} pairs written then read back on u0
  localparam logic [16:0] VEC [7] = '{
    {9'h000, 8'h5A}, {9'h1FF, 8'hC3}, {9'h100, 8'h11}, {9'h0FF, 8'hEE},
    {9'h0A5, 8'h3C}, {9'h17E, 8'h81}, {9'h001, 8'h27}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_pull = 1'b0; #Q;
    scl = 1'b1;    #Q;
    m_pull = 1'b1; #Q;
    scl = 1'b0;    #Q;
  endtask

  task automatic bus_stop();
    m_pull = 1'b1; #Q;
    scl = 1'b1;    #Q;
    m_pull = 1'b0; #(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_pull = ~b[i]; #Q;
      scl = 1'b1;     #(2*Q);
      scl = 1'b0;     #Q;
    end
    m_pull = 1'b0; #Q;
    scl = 1'b1;    #Q;
    ack = ~sda_line; #Q;
    scl = 1'b0;    #Q;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    m_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1'b1;
      #Q; b[i] = sda_line;
      #Q; scl = 1'b0;
      #Q;
    end
    m_pull = give_ack; #Q;
    scl = 1'b1;        #(2*Q);
    scl = 1'b0;        #Q;
    m_pull = 1'b0;
  endtask

  // select with write intent until acknowledged; returns attempts
  task automatic poll(input logic [7:0] sel, output int tries);
    bit a;
    tries = 0;
    a = 1'b0;
    while (!a && tries < 40) begin
      tries++;
      bus_start();
      send(sel, a);
      bus_stop();
    end
  endtask

  task automatic u0_write(input logic [8:0] addr, input logic [7:0] d);
    bit a;
    bus_start();
    send({4'b1010, 2'b00, addr[8], 1'b0}, a); chk(a, "R1 select ack", a, 1);
    send(addr[7:0], a);                       chk(a, "R3 address ack", a, 1);
    send(d, a);                               chk(a, "R3 data ack", a, 1);
    bus_stop();
    mdl0[addr] = d;
  endtask

  task automatic u0_read(input logic [8:0] addr, output logic [7:0] d);
    bit a;
    bus_start();
    send({4'b1010, 2'b00, addr[8], 1'b0}, a);
    send(addr[7:0], a);
    bus_start();
    send(8'hA1, a);
    recv(1'b0, d);
    bus_stop();
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tries;
    bit a;
    logic [7:0] d, d1, d2;
    #(CLK_NS * 4);
    chk(p0 == 1'b0 && p1 == 1'b0, "R11 reset release", {p1, p0}, 0);
    rst_n = 1'b1;
    #(CLK_NS * 10);

    // table walk: write, busy poll, random read back (R2 for 9-bit addresses)
    for (int v = 0; v < 7; v++) begin
      u0_write(VEC[v][16:8], VEC[v][7:0]);
      poll({4'b1010, 3'b000, 1'b0}, tries);
      if (v == 0) chk(tries > 1, "R7 select refused while busy", tries, 2);
      chk(tries < 40, "R7 select accepted after busy", tries, 2);
      u0_read(VEC[v][16:8], d);
      chk(d == mdl0[VEC[v][16:8]], "R2 R3 readback", d, mdl0[VEC[v][16:8]]);
    end
    chk(p0 == 1'b0, "R10 released while idle", p0, 0);

    // sequential write crossing the top of memory: 1FE, 1FF, 000
    bus_start();
    send(8'hA2, a); send(8'hFE, a);
    send(8'h71, a); send(8'h72, a); send(8'h73, a);
    chk(a, "R5 write across wrap acked", a, 1);
    bus_stop();
    mdl0[9'h1FE] = 8'h71; mdl0[9'h1FF] = 8'h72; mdl0[9'h000] = 8'h73;
    poll(8'hA0, tries);

    // sequential read across the wrap, ACK between bytes
    bus_start();
    send(8'hA2, a); send(8'hFE, a);
    bus_start();
    send(8'hA1, a);
    recv(1'b1, d); recv(1'b1, d1); recv(1'b0, d2);
    chk(d == 8'h71, "R4 first sequential byte", d, 8'h71);
    chk(d1 == 8'h72, "R4 second sequential byte", d1, 8'h72);
    chk(d2 == 8'h73, "R5 read wraps to zero", d2, 8'h73);
    chk(p0 == 1'b0, "R6 release after master NACK", p0, 0);
    #Q;
    chk(p0 == 1'b0, "R6 still released before STOP", p0, 0);
    bus_stop();

    // current-address read: pointer is now 001
    bus_start();
    send(8'hA1, a);
    recv(1'b0, d);
    bus_stop();
    chk(d == mdl0[1], "R4 pointer advanced after last byte", d, mdl0[1]);

    // foreign select bytes
    bus_start(); send(8'hA8, a); bus_stop();
    chk(!a, "R1 strap mismatch refused", a, 0);
    bus_start(); send(8'hB0, a); bus_stop();
    chk(!a, "R1 family code mismatch refused", a, 0);

    // write protection
    u0_write(9'h010, 8'h42);
    poll(8'hA0, tries);
    wp0 = 1'b1;
    bus_start();
    send(8'hA0, a);
    send(8'h10, a); chk(a, "R8 address still acked", a, 1);
    send(8'h99, a); chk(!a, "R8 data refused", a, 0);
    bus_stop();
    wp0 = 1'b0;
    bus_start(); send(8'hA0, a); bus_stop();
    chk(a, "R8 no busy period after refused data", a, 1);
    u0_read(9'h010, d);
    chk(d == 8'h42, "R8 protected byte unchanged", d, 8'h42);

    // wide-address device: select A A, two address bytes high first
    bus_start();
    send(8'hAA, a); chk(a, "R9 wide select ack", a, 1);
    send(8'h00, a); send(8'h37, a); send(8'h6D, a);
    chk(a, "R9 wide data ack", a, 1);
    bus_stop();
    poll(8'hAA, tries);
    bus_start();
    send(8'hAA, a); send(8'h00, a); send(8'h37, a);
    bus_start();
    send(8'hAB, a);
    recv(1'b0, d);
    bus_stop();
    chk(d == 8'h6D, "R9 wide readback", d, 8'h6D);
    bus_start(); send(8'hAE, a); bus_stop();
    chk(!a, "R9 all strap bits compared", a, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule